// File: doc/BRIEF.md
# Strap-Latched Clock Mode Controller

This block is the digital core of a board clock generator. Four of its pins do two jobs: while power-on reset is held, they are inputs that carry board straps set by pull-up or pull-down resistors. Once reset ends, the same pins carry clocks. The controller does three things:

- It captures the four strap levels into an internal configuration register.
- It then turns the shared pins into driven outputs.
- It decodes the captured bits into the controls the rest of the generator needs: a 3-bit frequency code for the CPU clock synthesizer, a bus-mode flag, a global output enable and a test-mode flag.

In normal operation the output groups are routed from synthesizer clocks that arrive as inputs. The CPU pin takes the CPU clock. The bus pin takes either the half-rate CPU clock or a fixed 32 MHz clock, depending on the bus-mode strap. The 48 MHz and 24 MHz pins take their own fixed clocks. In the production test code, the block instead divides the reference clock by 2, 3 and 4 and puts those clocks on the output groups. This exercises every pin without a running synthesizer. One further code disables all clock outputs.

Top module: `strap_clk_ctrl`

## Requirements
- R1: The strap register loads `strap_in` on the second rising edge of `ref_clk` after `por_n` goes high, and on no later edge. Bit 0 is the bus-mode strap; bits 1, 2 and 3 are frequency-select bits 0, 1 and 2.
- R2: `out_en` is 0 while `por_n` is low and on the sampling edge. It rises on the third rising edge after release, one edge after the sample. It falls at once, without waiting for a clock, when `por_n` goes low.
- R3: `cfg_cpu_code` equals the latched bits {fs2,fs1,fs0}. The codes select 000=50, 001=60, 010=66.6, 100=55, 101=75 and 110=83.3 MHz.
- R4: Code 111 sets `cfg_tristate` to 1 and holds `out_en` at 0 for as long as the code stays latched.
- R5: Code 011 sets `cfg_test` to 1. In that mode `cpu_out` and `clk48_out` carry REF/2, `clk24_out` carries REF/4 and `ref_out` follows `ref_clk`.
- R6: In test mode `bus_out` carries REF/4 when the bus strap is 1. When the bus strap is 0 it carries REF/3, which is low for one reference period and high for two.
- R7: All dividers hold phase zero (output low) until the sample edge. They make their first step on the third rising edge after release. After the k-th step the levels are: REF/2 = k mod 2; REF/4 = 1 when k mod 4 ≥ 2; REF/3 = 1 when k mod 3 ≠ 0.
- R8: Outside test mode, `cpu_out`, `clk48_out` and `clk24_out` pass `pll_cpu`, `pll_fix48` and `pll_fix24`. `bus_out` passes `pll_cpu_div2` when the bus strap is 1 and `pll_fix32` when it is 0. `cfg_bus_sync` equals the bus strap.
- R9: Strap changes after the sample edge do not change the configuration outputs. Reasserting `por_n` and releasing it again captures a fresh sample.
- R10: While `por_n` is low, the register reads as all ones (the pull-up value). The outputs are then `cfg_cpu_code`=7, `cfg_tristate`=1 and `cfg_bus_sync`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; clocks all logic and is the source of the divided test clocks |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| strap_in | input | 4 | Input levels of the shared pins: {fs2, fs1, fs0, bus strap} |
| pll_cpu | input | 1 | CPU clock from the synthesizer |
| pll_cpu_div2 | input | 1 | Half-rate CPU clock for synchronous bus mode |
| pll_fix32 | input | 1 | Fixed 32 MHz clock for asynchronous bus mode |
| pll_fix48 | input | 1 | Fixed 48 MHz clock |
| pll_fix24 | input | 1 | Fixed 24 MHz clock |
| out_en | output | 1 | Pad drive enable for every clock output; 0 means input or high impedance |
| cpu_out | output | 1 | CPU clock group |
| bus_out | output | 1 | Bus clock group |
| clk48_out | output | 1 | 48 MHz pin |
| clk24_out | output | 1 | 24 MHz pin |
| ref_out | output | 1 | Reference clock buffer |
| cfg_cpu_code | output | 3 | Latched frequency code for the synthesizer |
| cfg_bus_sync | output | 1 | 1 = bus synchronous at half CPU rate, 0 = fixed 32 MHz |
| cfg_test | output | 1 | Production test mode active |
| cfg_tristate | output | 1 | All-outputs-off code latched |

## Verification
The assertions assume that `por_n` is the only reset. They also assume that `por_n` stays high long enough after release for the synchronizer to finish, so that the divider wrap and register-hold properties see a full run of cycles. The bench drives `por_n` and every strap or synthesizer input between clock edges, 2 ns after a rising edge or at a falling edge. On every power-up it holds `por_n` low for several reference cycles. It also changes straps only at points where the design is meant to ignore them or to take them, never inside the sample edge itself.

// File: rtl/strapclk_pkg.sv
package strapclk_pkg;

  localparam int STRAP_W = 4;
  localparam int CODE_W  = 3;

  // Packed so that bit 0 is the bus strap and bits 3:1 are {fs2,fs1,fs0}
  typedef struct packed {
    logic [CODE_W-1:0] fsel;
    logic              bus_sel;
  } strap_t;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_TEST = 2'd1,
    MODE_OFF  = 2'd2
  } mode_e;

  localparam logic [CODE_W-1:0] CODE_TEST = 3'b011;
  localparam logic [CODE_W-1:0] CODE_OFF  = 3'b111;

  function automatic mode_e decode_mode(logic [CODE_W-1:0] fsel);
    if (fsel == CODE_OFF)       return MODE_OFF;
    else if (fsel == CODE_TEST) return MODE_TEST;
    else                        return MODE_RUN;
  endfunction

  // Next count of a modulo-div counter
  function automatic int div_step(int cnt, int div);
    return (cnt >= div - 1) ? 0 : cnt + 1;
  endfunction

  // Output level: high for the last 'high' counts of each period
  function automatic logic div_level(int cnt, int div, int high);
    return (cnt >= div - high);
  endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int W           = 4
) (
  input  logic         ref_clk,
  input  logic         por_n,
  input  logic [W-1:0] strap_in,
  output logic         rst_done,
  output logic         drive_en,
  output logic [W-1:0] strap_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   drive_q;
  logic                   sample_evt;

  // Asynchronous assert, synchronous release
  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= (sync_q << 1) | SYNC_STAGES'(1);
  end

  assign rst_done   = sync_q[SYNC_STAGES-1];
  assign sample_evt = !rst_done;

  // Register follows the pins until the release edge, then holds
  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n)          strap_q <= '1;
    else if (sample_evt) strap_q <= strap_in;
  end

  // Drivers turn on one edge after the last sample
  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) drive_q <= 1'b0;
    else        drive_q <= rst_done;
  end

  assign drive_en = drive_q;

  // R1 / R9: no change to the strap register once sampling has ended
  // R9
  latch_hold_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    rst_done |=> $stable(strap_q));

  // R2: pins are never driven while still being sampled
  drive_after_sample_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    drive_en |-> rst_done);

  // R2
  drive_delay_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    $rose(drive_en) |-> $past(rst_done));

endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strapclk_pkg::*;
(
  input  strap_t            cfg,
  output logic [CODE_W-1:0] cpu_code,
  output logic              bus_sync,
  output mode_e             mode,
  output logic              test_flag,
  output logic              off_flag
);

  always_comb begin
    cpu_code  = cfg.fsel;
    bus_sync  = cfg.bus_sel;
    mode      = decode_mode(cfg.fsel);
    test_flag = (mode == MODE_TEST);
    off_flag  = (mode == MODE_OFF);
  end

endmodule

// File: rtl/ref_divider.sv
module ref_divider
  import strapclk_pkg::*;
#(
  parameter int DIV  = 2,
  parameter int HIGH = 1
) (
  input  logic ref_clk,
  input  logic arst_n,
  input  logic run,
  output logic clk_out
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge ref_clk or negedge arst_n) begin
    if (!arst_n)   cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= CW'(div_step(int'(cnt), DIV));
  end

  assign clk_out = div_level(int'(cnt), DIV, HIGH);

  // R7
  cnt_range_chk: assert property (@(posedge ref_clk) disable iff (!arst_n)
    int'(cnt) <= DIV - 1);

  // R7
  cnt_wrap_chk: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (run && $past(run) && cnt == '0) |-> (int'($past(cnt)) == DIV - 1));

endmodule

// File: rtl/clk_route.sv
module clk_route
  import strapclk_pkg::*;
(
  input  mode_e mode,
  input  logic  bus_sel,
  input  logic  ref_clk,
  input  logic  div2,
  input  logic  div3,
  input  logic  div4,
  input  logic  pll_cpu,
  input  logic  pll_cpu_div2,
  input  logic  pll_fix32,
  input  logic  pll_fix48,
  input  logic  pll_fix24,
  output logic  cpu_out,
  output logic  bus_out,
  output logic  clk48_out,
  output logic  clk24_out,
  output logic  ref_out
);

  always_comb begin
    ref_out = ref_clk;
    unique case (mode)
      MODE_TEST: begin
        cpu_out   = div2;
        clk48_out = div2;
        clk24_out = div4;
        bus_out   = bus_sel ? div4 : div3;
      end
      MODE_OFF: begin
        cpu_out   = 1'b0;
        clk48_out = 1'b0;
        clk24_out = 1'b0;
        bus_out   = 1'b0;
      end
      default: begin
        cpu_out   = pll_cpu;
        clk48_out = pll_fix48;
        clk24_out = pll_fix24;
        bus_out   = bus_sel ? pll_cpu_div2 : pll_fix32;
      end
    endcase
  end

endmodule

// File: rtl/strap_clk_ctrl.sv
module strap_clk_ctrl
  import strapclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               por_n,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic               pll_cpu,
  input  logic               pll_cpu_div2,
  input  logic               pll_fix32,
  input  logic               pll_fix48,
  input  logic               pll_fix24,
  output logic               out_en,
  output logic               cpu_out,
  output logic               bus_out,
  output logic               clk48_out,
  output logic               clk24_out,
  output logic               ref_out,
  output logic [CODE_W-1:0]  cfg_cpu_code,
  output logic               cfg_bus_sync,
  output logic               cfg_test,
  output logic               cfg_tristate
);

  localparam int NDIV = 3;
  localparam int DIV_RATIO [NDIV] = '{2, 4, 3};
  localparam int DIV_HIGH  [NDIV] = '{1, 2, 2};

  logic               rst_done;
  logic               drive_en;
  logic [STRAP_W-1:0] strap_q;
  strap_t             cfg;
  mode_e              mode;
  logic [NDIV-1:0]    div_clk;

  strap_capture #(.SYNC_STAGES(SYNC_STAGES), .W(STRAP_W)) u_cap (
    .ref_clk  (ref_clk),
    .por_n    (por_n),
    .strap_in (strap_in),
    .rst_done (rst_done),
    .drive_en (drive_en),
    .strap_q  (strap_q)
  );

  assign cfg = strap_t'(strap_q);

  strap_decode u_dec (
    .cfg       (cfg),
    .cpu_code  (cfg_cpu_code),
    .bus_sync  (cfg_bus_sync),
    .mode      (mode),
    .test_flag (cfg_test),
    .off_flag  (cfg_tristate)
  );

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    ref_divider #(.DIV(DIV_RATIO[g]), .HIGH(DIV_HIGH[g])) u_div (
      .ref_clk (ref_clk),
      .arst_n  (por_n),
      .run     (rst_done),
      .clk_out (div_clk[g])
    );
  end

  clk_route u_route (
    .mode         (mode),
    .bus_sel      (cfg.bus_sel),
    .ref_clk      (ref_clk),
    .div2         (div_clk[0]),
    .div3         (div_clk[2]),
    .div4         (div_clk[1]),
    .pll_cpu      (pll_cpu),
    .pll_cpu_div2 (pll_cpu_div2),
    .pll_fix32    (pll_fix32),
    .pll_fix48    (pll_fix48),
    .pll_fix24    (pll_fix24),
    .cpu_out      (cpu_out),
    .bus_out      (bus_out),
    .clk48_out    (clk48_out),
    .clk24_out    (clk24_out),
    .ref_out      (ref_out)
  );

  assign out_en = drive_en && (mode != MODE_OFF);

  // R4
  tristate_off_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    cfg_tristate |-> !out_en);

  // R5
  test_pair_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    (cfg_test && out_en) |-> (cpu_out == clk48_out));

  // R2
  no_drive_in_reset_chk: assert property (@(posedge ref_clk) disable iff (!por_n)
    !rst_done |-> !out_en);

endmodule

// File: tb/strap_clk_ctrl_test.sv
module strap_clk_ctrl_test;

  localparam time CLK_P = 10ns;

  logic       ref_clk = 1'b0;
  logic       por_n   = 1'b0;
  logic [3:0] strap_in = 4'hF;
  logic       pll_cpu = 0, pll_cpu_div2 = 0, pll_fix32 = 0, pll_fix48 = 0, pll_fix24 = 0;
  logic       out_en, cpu_out, bus_out, clk48_out, clk24_out, ref_out;
  logic [2:0] cfg_cpu_code;
  logic       cfg_bus_sync, cfg_test, cfg_tristate;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) ref_clk = ~ref_clk;

  strap_clk_ctrl uut (
    .ref_clk(ref_clk), .por_n(por_n), .strap_in(strap_in),
    .pll_cpu(pll_cpu), .pll_cpu_div2(pll_cpu_div2), .pll_fix32(pll_fix32),
    .pll_fix48(pll_fix48), .pll_fix24(pll_fix24),
    .out_en(out_en), .cpu_out(cpu_out), .bus_out(bus_out),
    .clk48_out(clk48_out), .clk24_out(clk24_out), .ref_out(ref_out),
    .cfg_cpu_code(cfg_cpu_code), .cfg_bus_sync(cfg_bus_sync),
    .cfg_test(cfg_test), .cfg_tristate(cfg_tristate)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Holds reset, checks the reset state, releases and walks through the
  // sample edge. Returns 2 ns after the third rising edge (first divider step).
  task automatic power_up(logic [3:0] val);
    por_n = 1'b0;
    strap_in = 4'hF;
    repeat (3) @(posedge ref_clk);
    #2ns;
    chk("R10", "reset code", cfg_cpu_code, 3'd7);
    chk("R10", "reset tristate", cfg_tristate, 1'b1);
    chk("R10", "reset bus_sync", cfg_bus_sync, 1'b1);
    chk("R2", "oe in reset", out_en, 1'b0);
    @(negedge ref_clk);
    por_n = 1'b1;
    strap_in = ~val;                 // decoy seen by the first edge
    @(posedge ref_clk); #2ns;
    chk("R2", "oe edge1", out_en, 1'b0);
    strap_in = val;                  // value for the sample edge
    @(posedge ref_clk); #2ns;
    chk("R1", "sampled code", cfg_cpu_code, val[3:1]);
    chk("R1", "sampled bus", cfg_bus_sync, val[0]);
    chk("R2", "oe on sample edge", out_en, 1'b0);
    strap_in = ~val;                 // late change, must be ignored
    @(posedge ref_clk); #2ns;
    chk("R2", "oe edge3", out_en, (val[3:1] != 3'b111));
  endtask

  task automatic test_mode_run(logic bsel);
    logic [3:0] val;
    val = {3'b011, bsel};
    power_up(val);
    chk("R5", "test flag", cfg_test, 1'b1);
    chk("R3", "test code", cfg_cpu_code, 3'b011);
    for (int k = 1; k <= 12; k++) begin
      logic e2, e3, e4;
      e2 = (k % 2) == 1;
      e4 = (k % 4) >= 2;
      e3 = (k % 3) != 0;
      chk("R7", "cpu REF/2", cpu_out, e2);
      chk("R5", "48 REF/2", clk48_out, e2);
      chk("R5", "24 REF/4", clk24_out, e4);
      chk("R6", "bus div", bus_out, bsel ? e4 : e3);
      chk("R5", "ref high", ref_out, 1'b1);
      @(posedge ref_clk); #2ns;
    end
    @(negedge ref_clk); #1ns;
    chk("R5", "ref low", ref_out, 1'b0);
    chk("R9", "code kept", cfg_cpu_code, 3'b011);
  endtask

  task automatic normal_run(logic [2:0] code, logic bsel);
    power_up({code, bsel});
    chk("R3", "code", cfg_cpu_code, code);
    chk("R8", "bus_sync", cfg_bus_sync, bsel);
    chk("R5", "no test", cfg_test, 1'b0);
    chk("R4", "no tristate", cfg_tristate, 1'b0);
    for (int p = 0; p < 2; p++) begin
      pll_cpu = p[0]; pll_cpu_div2 = ~p[0]; pll_fix32 = p[0];
      pll_fix48 = ~p[0]; pll_fix24 = p[0];
      #1ns;
      chk("R8", "cpu route", cpu_out, pll_cpu);
      chk("R8", "bus route", bus_out, bsel ? pll_cpu_div2 : pll_fix32);
      chk("R8", "48 route", clk48_out, pll_fix48);
      chk("R8", "24 route", clk24_out, pll_fix24);
      chk("R8", "oe", out_en, 1'b1);
    end
    repeat (4) @(posedge ref_clk);
    #2ns;
    chk("R9", "late strap ignored", cfg_cpu_code, code);
    chk("R9", "late bus ignored", cfg_bus_sync, bsel);
  endtask

  task automatic tristate_run();
    power_up(4'b1110);
    for (int k = 0; k < 4; k++) begin
      chk("R4", "tristate flag", cfg_tristate, 1'b1);
      chk("R4", "oe held off", out_en, 1'b0);
      @(posedge ref_clk); #2ns;
    end
  endtask

  task automatic reassert_run();
    power_up(4'b0101);               // code 010, bus strap 1
    chk("R3", "code 010", cfg_cpu_code, 3'b010);
    @(posedge ref_clk); #3ns;
    por_n = 1'b0;
    #1ns;
    chk("R2", "oe async off", out_en, 1'b0);
    chk("R10", "pull-up value", cfg_cpu_code, 3'd7);
    power_up(4'b1010);               // code 101, bus strap 0
    chk("R9", "fresh sample code", cfg_cpu_code, 3'b101);
    chk("R9", "fresh sample bus", cfg_bus_sync, 1'b0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    test_mode_run(1'b1);
    test_mode_run(1'b0);
    normal_run(3'b000, 1'b1);
    normal_run(3'b110, 1'b0);
    normal_run(3'b101, 1'b1);
    tristate_run();
    reassert_run();
    finish_run();
  end

endmodule